// File: doc/BRIEF.md
# Descriptor Ring Sequencer

This block keeps a table of 64-bit buffer descriptors and hands their ownership back and forth between software and two frame engines. Each descriptor is a control/status word plus a buffer address word. A register bus reads and writes the whole table and three control registers. A programmable count splits the table: the leading entries form the transmit ring and the rest form the receive ring. Each ring has its own pointer, and a per-descriptor wrap flag closes the ring early.

On the transmit side the sequencer waits until software marks the entry under its pointer as ready. It then presents that entry's length, address, CRC and padding requests to a frame source and holds them until the source reports completion with a status vector. The status is written back, the ready flag is cleared and the pointer moves on. On the receive side each arriving frame is placed in the current descriptor if software has marked it empty. The length and status are written back and the empty flag is cleared. If the descriptor is not empty the frame is dropped and a busy event is flagged. Completions raise interrupt source bits, and a mask register gates them onto a single interrupt line.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset the transmit count reads NUM_BD/2, the interrupt source and mask read 0, irq_o and tx_req are low, and every descriptor word reads 0.
- R2: The transmit count register is at bus address 0x08. A written value above NUM_BD is stored as NUM_BD. Every write to it restarts the transmit pointer at entry 0 and the receive pointer at entry `count`.
- R3: Descriptor i has its control/status word at bus address 0x400+8*i and its address word at 0x404+8*i. The interrupt source is at 0x00 and the mask at 0x04. All of these read back what was written.
- R4: When bit 15 (ready) of the descriptor at the transmit pointer is set, tx_req rises on the next cycle. While tx_req is high, tx_len shows bits 31:16, tx_addr shows the address word, tx_crc shows bit 11 and tx_pad shows bit 12. tx_req stays high until tx_done.
- R5: While the descriptor at the transmit pointer has bit 15 clear, tx_req stays low and the transmit pointer does not move.
- R6: On tx_done the descriptor's bits 8:0 take tx_status and bit 15 is cleared; all other bits are kept. The pointer then goes to entry 0 if bit 13 (wrap) was set or the entry was the last transmit entry. Otherwise it advances by one.
- R7: rx_addr shows the address word at the receive pointer. On rx_valid, if that descriptor has bit 15 (empty) set, its control word becomes {rx_len, 0, old bits 14:9, rx_status}. The pointer then goes to entry `count` if bit 13 was set or the entry is the last table entry. Otherwise it advances by one.
- R8: A completion whose descriptor has bit 14 set raises an interrupt source bit; with bit 14 clear, no source bit changes. For transmit it raises bit 0 if tx_status is zero and bit 1 otherwise. For receive it raises bit 2 if rx_status bits 7:0 are zero and bit 3 otherwise, and also bit 6 if rx_status bit 8 is set.
- R9: On rx_valid, if the current descriptor lacks bit 15 or the receive ring is empty (count = NUM_BD), no descriptor changes, the pointer holds, and source bit 4 is set regardless of bit 14.
- R10: Writing 1 to a source bit clears it, and a new event in the same cycle wins over the clear. irq_o is high exactly when some source bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 12 | Register bus byte address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational) |
| tx_req | output | 1 | A transmit descriptor is being served |
| tx_len | output | 16 | Frame length of the served descriptor |
| tx_addr | output | 32 | Buffer address of the served descriptor |
| tx_crc | output | 1 | CRC append requested |
| tx_pad | output | 1 | Short-frame padding requested |
| tx_done | input | 1 | Frame source finished the served descriptor |
| tx_status | input | 9 | Transmit completion status |
| rx_valid | input | 1 | One-cycle pulse: a frame has arrived |
| rx_len | input | 16 | Length of the arrived frame |
| rx_status | input | 9 | Receive status of the arrived frame |
| rx_addr | output | 32 | Buffer address at the receive pointer |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the block with NUM_BD = 8, so both rings are only a few entries long. This lets every pointer path be reached in a few cycles: the wrap flag, the implicit wrap at the last transmit entry and at the last table entry, and restarts at different split points. With eight entries the bench can also clamp an oversize count and empty the receive ring entirely, which brings the dropped-frame path for a zero-length receive ring within reach.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int BUS_AW   = 12;
  localparam int IRQ_W    = 7;
  localparam int B_OWN    = 15;
  localparam int B_IRQ    = 14;
  localparam int B_WRAP   = 13;
  localparam int B_PAD    = 12;
  localparam int B_CRC    = 11;
  localparam int S_TXF    = 0;
  localparam int S_TXE    = 1;
  localparam int S_RXF    = 2;
  localparam int S_RXE    = 3;
  localparam int S_BUSY   = 4;
  localparam int S_RXC    = 6;

  // next ring index: back to first on wrap flag or at the ring's end
  function automatic int ring_next(int cur, logic wrap, int first, int last);
    if (wrap || cur >= last) return first;
    return cur + 1;
  endfunction

  function automatic logic [31:0] tx_close(logic [31:0] w, logic [8:0] st);
    logic [31:0] r;
    r = w;
    r[B_OWN] = 1'b0;
    r[8:0] = st;
    return r;
  endfunction

  function automatic logic [31:0] rx_close(logic [31:0] w, logic [15:0] len,
                                           logic [8:0] st);
    return {len, 1'b0, w[14:9], st};
  endfunction

  function automatic logic [IRQ_W-1:0] tx_events(logic req, logic [8:0] st);
    logic [IRQ_W-1:0] e;
    e = '0;
    if (req) begin
      if (st == 9'd0) e[S_TXF] = 1'b1;
      else            e[S_TXE] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [IRQ_W-1:0] rx_events(logic req, logic [8:0] st);
    logic [IRQ_W-1:0] e;
    e = '0;
    if (req) begin
      if (st[7:0] == 8'd0) e[S_RXF] = 1'b1;
      else                 e[S_RXE] = 1'b1;
      e[S_RXC] = st[8];
    end
    return e;
  endfunction

  function automatic logic [31:0] clamp_cnt(logic [31:0] v, int lim);
    if (v > 32'(lim)) return 32'(lim);
    return v;
  endfunction
endpackage

// File: rtl/bdr_tx_walk.sv
module bdr_tx_walk #(
  parameter int NUM_BD = 32,
  localparam int PTR_W = $clog2(NUM_BD),
  localparam int CNT_W = $clog2(NUM_BD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] txcnt,
  input  logic [31:0]      cur_word,
  input  logic             done,
  output logic [PTR_W-1:0] ptr,
  output logic             busy,
  output logic             fin
);
  logic start;
  assign start = !busy && !restart && (txcnt != '0) && cur_word[bdr_pkg::B_OWN];
  assign fin   = busy && done && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      busy <= 1'b0;
    end else if (restart) begin
      ptr  <= '0;
      busy <= 1'b0;
    end else begin
      if (start) busy <= 1'b1;
      if (fin) begin
        busy <= 1'b0;
        ptr  <= PTR_W'(bdr_pkg::ring_next(int'(ptr), cur_word[bdr_pkg::B_WRAP],
                                          0, int'(txcnt) - 1));
      end
    end
  end
endmodule

// File: rtl/bdr_rx_walk.sv
module bdr_rx_walk #(
  parameter int NUM_BD = 32,
  localparam int CNT_W = $clog2(NUM_BD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] new_base,
  input  logic [CNT_W-1:0] txcnt,
  input  logic [31:0]      cur_word,
  input  logic             frame,
  output logic [CNT_W-1:0] ptr,
  output logic             fin,
  output logic             drop
);
  logic ring_ok;
  assign ring_ok = int'(txcnt) < NUM_BD;
  assign fin  = frame && ring_ok && cur_word[bdr_pkg::B_OWN];
  assign drop = frame && !fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= CNT_W'(NUM_BD / 2);
    end else if (restart) begin
      ptr <= new_base;
    end else if (fin) begin
      ptr <= CNT_W'(bdr_pkg::ring_next(int'(ptr), cur_word[bdr_pkg::B_WRAP],
                                       int'(txcnt), NUM_BD - 1));
    end
  end
endmodule

// File: rtl/bdr_irq.sv
module bdr_irq #(
  parameter int IRQ_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] src,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic [IRQ_W-1:0] clr;
  assign clr = clr_we ? wdata : '0;
  assign irq = |(src & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      mask <= '0;
    end else begin
      src <= (src & ~clr) | set;
      if (mask_we) mask <= wdata;
    end
  end
endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq #(
  parameter int NUM_BD = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_req,
  output logic [15:0] tx_len,
  output logic [31:0] tx_addr,
  output logic        tx_crc,
  output logic        tx_pad,
  input  logic        tx_done,
  input  logic [8:0]  tx_status,
  input  logic        rx_valid,
  input  logic [15:0] rx_len,
  input  logic [8:0]  rx_status,
  output logic [31:0] rx_addr,
  output logic        irq_o
);
  import bdr_pkg::*;
  localparam int PTR_W = $clog2(NUM_BD);
  localparam int CNT_W = $clog2(NUM_BD + 1);

  logic [31:0]      bd_stat [NUM_BD];
  logic [31:0]      bd_addr [NUM_BD];
  logic [CNT_W-1:0] txcnt;
  logic [CNT_W-1:0] cnt_new;
  logic [PTR_W-1:0] tx_ptr;
  logic [CNT_W-1:0] rx_ptr;
  logic             tx_busy, tx_fin, rx_fin, rx_drop, restart;
  logic [31:0]      tx_word, rx_word, tx_aw, rx_aw;
  logic [IRQ_W-1:0] irq_src, irq_mask, irq_set;
  logic             tbl_sel, reg_sel;
  logic [6:0]       bus_idx;
  logic [7:0]       reg_word;

  // bus decode
  assign tbl_sel  = bus_addr[11:10] == 2'b01;
  assign reg_sel  = bus_addr[11:10] == 2'b00;
  assign bus_idx  = bus_addr[9:3];
  assign reg_word = bus_addr[9:2];
  assign restart  = bus_we && reg_sel && reg_word == 8'd2;
  assign cnt_new  = CNT_W'(clamp_cnt(bus_wdata, NUM_BD));

  always_ff @(posedge clk) begin
    if (!rst_n)       txcnt <= CNT_W'(NUM_BD / 2);
    else if (restart) txcnt <= cnt_new;
  end

  // current descriptors seen by the two engines
  always_comb begin
    tx_word = '0;
    tx_aw   = '0;
    rx_word = '0;
    rx_aw   = '0;
    if (int'(tx_ptr) < NUM_BD) begin
      tx_word = bd_stat[tx_ptr];
      tx_aw   = bd_addr[tx_ptr];
    end
    if (int'(rx_ptr) < NUM_BD) begin
      rx_word = bd_stat[PTR_W'(rx_ptr)];
      rx_aw   = bd_addr[PTR_W'(rx_ptr)];
    end
  end

  bdr_tx_walk #(.NUM_BD(NUM_BD)) u_tx (
    .clk(clk), .rst_n(rst_n), .restart(restart), .txcnt(txcnt),
    .cur_word(tx_word), .done(tx_done), .ptr(tx_ptr), .busy(tx_busy),
    .fin(tx_fin)
  );

  bdr_rx_walk #(.NUM_BD(NUM_BD)) u_rx (
    .clk(clk), .rst_n(rst_n), .restart(restart), .new_base(cnt_new),
    .txcnt(txcnt), .cur_word(rx_word), .frame(rx_valid), .ptr(rx_ptr),
    .fin(rx_fin), .drop(rx_drop)
  );

  always_comb begin
    irq_set = tx_events(tx_fin && tx_word[B_IRQ], tx_status)
            | rx_events(rx_fin && rx_word[B_IRQ], rx_status);
    irq_set[S_BUSY] = rx_drop;
  end

  bdr_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set),
    .clr_we(bus_we && reg_sel && reg_word == 8'd0),
    .mask_we(bus_we && reg_sel && reg_word == 8'd1),
    .wdata(bus_wdata[IRQ_W-1:0]), .src(irq_src), .mask(irq_mask), .irq(irq_o)
  );

  // descriptor table: engine write-back has priority over the bus
  for (genvar i = 0; i < NUM_BD; i++) begin : g_bd
    logic [31:0] stat_q, addr_q;
    logic        hit;
    assign hit = bus_we && tbl_sel && int'(bus_idx) == i;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_q <= '0;
        addr_q <= '0;
      end else begin
        if (tx_fin && int'(tx_ptr) == i)      stat_q <= tx_close(stat_q, tx_status);
        else if (rx_fin && int'(rx_ptr) == i) stat_q <= rx_close(stat_q, rx_len, rx_status);
        else if (hit && !bus_addr[2])          stat_q <= bus_wdata;
        if (hit && bus_addr[2]) addr_q <= bus_wdata;
      end
    end
    assign bd_stat[i] = stat_q;
    assign bd_addr[i] = addr_q;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (tbl_sel) begin
      if (int'(bus_idx) < NUM_BD)
        bus_rdata = bus_addr[2] ? bd_addr[PTR_W'(bus_idx)] : bd_stat[PTR_W'(bus_idx)];
    end else if (reg_sel) begin
      case (reg_word)
        8'd0:    bus_rdata = 32'(irq_src);
        8'd1:    bus_rdata = 32'(irq_mask);
        8'd2:    bus_rdata = 32'(txcnt);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign tx_req  = tx_busy;
  assign tx_len  = tx_word[31:16];
  assign tx_addr = tx_aw;
  assign tx_crc  = tx_word[B_CRC];
  assign tx_pad  = tx_word[B_PAD];
  assign rx_addr = rx_aw;
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker #(
  parameter int NUM_BD = 32,
  localparam int PTR_W = $clog2(NUM_BD),
  localparam int CNT_W = $clog2(NUM_BD + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] txcnt,
  input logic [PTR_W-1:0] tx_ptr,
  input logic [CNT_W-1:0] rx_ptr,
  input logic             tx_fin,
  input logic             restart,
  input logic             rx_drop,
  input logic [6:0]       irq_src,
  input logic             irq_o
);
  AST_CNT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    txcnt <= CNT_W'(NUM_BD)); // R2
  AST_TX_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (txcnt != '0) |-> (CNT_W'(tx_ptr) < txcnt)); // R6
  AST_RX_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ptr >= txcnt) && (rx_ptr <= CNT_W'(NUM_BD))); // R7
  AST_TX_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fin && !restart) |=> $stable(tx_ptr)); // R5
  AST_DROP_FLAGS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> irq_src[4]); // R9
  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_src != 7'd0)); // R10
endmodule

bind bd_ring_seq bdr_checker #(.NUM_BD(NUM_BD)) u_chk (
  .clk(clk), .rst_n(rst_n), .txcnt(txcnt), .tx_ptr(tx_ptr), .rx_ptr(rx_ptr),
  .tx_fin(tx_fin), .restart(restart), .rx_drop(rx_drop), .irq_src(irq_src),
  .irq_o(irq_o)
);

// File: tb/test_bd_ring_seq.sv
module test_bd_ring_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NBD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_req, tx_crc, tx_pad, irq_o;
  logic [15:0] tx_len;
  logic [31:0] tx_addr, rx_addr;
  logic        tx_done = 1'b0;
  logic [8:0]  tx_status = '0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_len = '0;
  logic [8:0]  rx_status = '0;
  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bd_ring_seq #(.NUM_BD(NBD)) i_bd_ring_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req),
    .tx_len(tx_len), .tx_addr(tx_addr), .tx_crc(tx_crc), .tx_pad(tx_pad),
    .tx_done(tx_done), .tx_status(tx_status), .rx_valid(rx_valid),
    .rx_len(rx_len), .rx_status(rx_status), .rx_addr(rx_addr), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [11:0] st_a(input int i);
    return 12'(12'h400 + 8 * i);
  endfunction

  function automatic logic [11:0] ad_a(input int i);
    return 12'(12'h404 + 8 * i);
  endfunction

  task automatic finish_tx(input logic [8:0] st);
    tx_done = 1'b1; tx_status = st;
    @(negedge clk);
    tx_done = 1'b0; tx_status = '0;
  endtask

  task automatic frame_in(input logic [15:0] len, input logic [8:0] st);
    @(negedge clk);
    rx_valid = 1'b1; rx_len = len; rx_status = st;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h008, d); chk("R1 count after reset", d, NBD / 2);
    rd(12'h000, d); chk("R1 source after reset", d, 0);
    rd(12'h004, d); chk("R1 mask after reset", d, 0);
    rd(st_a(0), d); chk("R1 descriptor after reset", d, 0);
    chk("R1 irq_o after reset", 32'(irq_o), 0);
    chk("R1 tx_req after reset", 32'(tx_req), 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(12'h008, 200); rd(12'h008, d); chk("R2 count clamp", d, NBD);
    wr(12'h008, 3);   rd(12'h008, d); chk("R2 count plain", d, 3);
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    wr(12'h008, 4);
    wr(ad_a(0), 32'h1000);
    rd(ad_a(0), d); chk("R3 address word", d, 32'h1000);
    wr(st_a(0), 32'h003C_D800);
    @(negedge clk);
    chk("R4 tx_req", 32'(tx_req), 1);
    chk("R4 tx_len", 32'(tx_len), 32'h3C);
    chk("R4 tx_addr", tx_addr, 32'h1000);
    chk("R4 crc/pad", {30'd0, tx_crc, tx_pad}, 3);
    repeat (2) @(negedge clk);
    chk("R4 tx_req held", 32'(tx_req), 1);
    finish_tx(9'd0);
    chk("R4 tx_req drops", 32'(tx_req), 0);
    rd(st_a(0), d); chk("R6 close word", d, 32'h003C_5800);
    rd(12'h000, d); chk("R8 tx frame source", d, 32'h01);
    chk("R10 masked off", 32'(irq_o), 0);
    wr(12'h004, 32'h7F);
    rd(12'h004, d); chk("R3 mask readback", d, 32'h7F);
    chk("R10 irq on", 32'(irq_o), 1);
    wr(12'h000, 32'h01);
    rd(12'h000, d); chk("R10 w1c", d, 0);
    chk("R10 irq off", 32'(irq_o), 0);
  endtask

  task automatic t_tx_stall_err;
    logic [31:0] d;
    repeat (4) @(negedge clk);
    chk("R5 stall no req", 32'(tx_req), 0);
    wr(ad_a(1), 32'h2000);
    wr(st_a(1), 32'h0014_8000);
    @(negedge clk);
    chk("R5 resumes at entry 1", tx_addr, 32'h2000);
    finish_tx(9'h014);
    rd(st_a(1), d); chk("R6 status written", d, 32'h0014_0014);
    rd(12'h000, d); chk("R8 no irq bit no source", d, 0);
    wr(ad_a(2), 32'h3000);
    wr(st_a(2), 32'h001E_C000);
    @(negedge clk);
    finish_tx(9'h100);
    rd(12'h000, d); chk("R8 tx error source", d, 32'h02);
    wr(12'h000, 32'h7F);
  endtask

  task automatic t_tx_wrap;
    wr(12'h008, 4);
    wr(st_a(0), 32'h0005_A000);
    @(negedge clk);
    finish_tx(9'd0);
    wr(st_a(0), 32'h0007_8000);
    @(negedge clk);
    chk("R6 wrap flag returns to 0", tx_addr, 32'h1000);
    chk("R6 wrap flag len", 32'(tx_len), 7);
    finish_tx(9'd0);
    wr(12'h008, 2);
    wr(st_a(0), 32'h0001_8000);
    @(negedge clk);
    finish_tx(9'd0);
    wr(st_a(1), 32'h0002_8000);
    @(negedge clk);
    chk("R6 second entry", tx_addr, 32'h2000);
    finish_tx(9'd0);
    wr(st_a(0), 32'h0003_8000);
    @(negedge clk);
    chk("R6 end of ring wraps", 32'(tx_len), 3);
    finish_tx(9'd0);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    for (int i = 4; i < 8; i++) wr(ad_a(i), 32'(i * 32'h1000));
    wr(st_a(4), 32'h0000_C000);
    wr(st_a(5), 32'h0);
    wr(st_a(6), 32'h0000_E000);
    wr(12'h008, 4);
    wr(12'h000, 32'h7F);
    chk("R2 restart rx pointer", rx_addr, 32'h4000);
    frame_in(16'd100, 9'd0);
    rd(st_a(4), d); chk("R7 rx close word", d, 32'h0064_4000);
    rd(12'h000, d); chk("R8 rx frame source", d, 32'h04);
    chk("R7 rx advance", rx_addr, 32'h5000);
    frame_in(16'd50, 9'd0);
    rd(st_a(5), d); chk("R9 busy desc unchanged", d, 0);
    rd(12'h000, d); chk("R9 busy source", d, 32'h14);
    chk("R9 pointer holds", rx_addr, 32'h5000);
    wr(12'h000, 32'h7F);
    wr(st_a(5), 32'h0000_C000);
    frame_in(16'd40, 9'h002);
    rd(st_a(5), d); chk("R7 rx status word", d, 32'h0028_4002);
    rd(12'h000, d); chk("R8 rx error source", d, 32'h08);
    wr(12'h000, 32'h7F);
    frame_in(16'd64, 9'h100);
    rd(st_a(6), d); chk("R7 rx wrap entry", d, 32'h0040_6100);
    rd(12'h000, d); chk("R8 rx control source", d, 32'h44);
    chk("R7 wrap flag back to base", rx_addr, 32'h4000);
    wr(12'h000, 32'h7F);
    wr(12'h008, 6);
    chk("R2 restart at new base", rx_addr, 32'h6000);
    wr(st_a(6), 32'h0000_8000);
    wr(st_a(7), 32'h0000_8000);
    frame_in(16'd1, 9'd0);
    rd(12'h000, d); chk("R8 rx no irq bit", d, 0);
    chk("R7 step to last", rx_addr, 32'h7000);
    frame_in(16'd2, 9'd0);
    chk("R7 end of table wraps", rx_addr, 32'h6000);
    wr(12'h008, NBD);
    frame_in(16'd3, 9'd0);
    rd(12'h000, d); chk("R9 empty rx ring drops", d, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_tx_basic();
    t_tx_stall_err();
    t_tx_wrap();
    t_rx();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule